// File: doc/BRIEF.md
# Bridge I/O Forwarding Decoder

This block sits at the downstream side of a virtual host-to-PCI Express bridge. It decides, for every I/O access issued by the processor, whether the access is claimed and sent to the secondary link. It holds a 16-bit bridge control word, written through a byte-enabled port. The decision combines three rules. The first is an inclusive I/O window given by base and limit inputs. The second is an optional ISA alias hole that withholds the upper three quarters of every 1 KB block. The third is a legacy VGA I/O decode that can compare either the low ten address bits or the full address.

The caller presents an address with a valid strobe. One clock later the block returns a registered valid and a forward flag. One control bit requests a hot reset of the secondary link for as long as it stays set.

Top module: `io_fwd_decoder`

## Requirements
- R1: After reset the control word reads 0000h, `hot_reset_req` is 0 and `fwd_valid` and `fwd_hit` are 0.
- R2: Control bits 15:7, 5, 1 and 0 always read 0, whatever value is written to them.
- R3: Control bits 2, 3, 4 and 6 take the written value on the clock edge where `reg_wr_en` and `reg_be[0]` are both 1. That value reads back from the next cycle on. With `reg_be[0]` at 0 these bits keep their value.
- R4: With bit 2 at 0, an address A is forwarded when `io_base` <= A <= `io_limit`, both bounds included. When `io_base` > `io_limit` no address is forwarded by the window.
- R5: With bit 2 at 1, a window address whose bits [9:8] are not 00 is not forwarded. Window addresses whose bits [9:8] are 00 are still forwarded.
- R6: Bit 2 never causes an address outside the window to be forwarded.
- R7: With bit 3 at 1, an address whose low ten bits lie in 3B0h–3BBh or 3C0h–3DFh is forwarded. This holds even outside the window and inside the ISA hole.
- R8: With bits 3 and 4 at 1, the VGA match also needs address bits [15:10] to be zero. With bit 3 at 1 and bit 4 at 0, aliases such as 7C0h match.
- R9: With bit 3 at 0, bit 4 has no effect on forwarding.
- R10: `hot_reset_req` equals control bit 6 in every cycle.
- R11: `fwd_valid` is 1 exactly one cycle after a cycle with `req_valid` at 1. `fwd_hit` is 0 whenever `fwd_valid` is 0. The decision uses the control word as it stood before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_be | input | 2 | Byte enables for the write, bit 0 covers bits 7:0 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| io_base | input | 16 | Lowest address of the I/O window |
| io_limit | input | 16 | Highest address of the I/O window |
| req_valid | input | 1 | Address valid strobe |
| req_addr | input | 16 | Processor I/O address |
| fwd_valid | output | 1 | Decision valid, one cycle after `req_valid` |
| fwd_hit | output | 1 | Access is forwarded to the secondary link |
| hot_reset_req | output | 1 | Hot-reset request toward the link |

## Verification
The only internal state is the control word and the one-cycle result stage. A wrong value in either shows at the ports no later than the next negative clock edge. A corrupted control bit appears directly on `reg_rdata` and, for bit 6, on `hot_reset_req`. It then appears in the following forwarding decisions for window, hole and VGA addresses. A broken result stage shows up as a missing or extra `fwd_valid` pulse, or as a `fwd_hit` that disagrees with a reference model run on the same stimulus in the same cycle.

// File: rtl/iofd_pkg.sv
package iofd_pkg;

   // Control word bit positions decoded by the forwarding logic
   localparam int unsigned ISA_BIT   = 2;
   localparam int unsigned VGA_BIT   = 3;
   localparam int unsigned VGA16_BIT = 4;
   localparam int unsigned SBR_BIT   = 6;

   // Low ten bits of the legacy VGA I/O ranges
   localparam int unsigned VGA_NRANGE = 2;
   localparam int unsigned VGA_LO [VGA_NRANGE] = '{10'h3B0, 10'h3C0};
   localparam int unsigned VGA_HI [VGA_NRANGE] = '{10'h3BB, 10'h3DF};

   // Alias span for legacy decodes (address bits below this are compared)
   localparam int unsigned ALIAS_BITS = 10;

   function automatic logic [15:0] rw_mask16();
      logic [15:0] m;
      m = '0;
      m[ISA_BIT]   = 1'b1;
      m[VGA_BIT]   = 1'b1;
      m[VGA16_BIT] = 1'b1;
      m[SBR_BIT]   = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/iofd_ctl_reg.sv
module iofd_ctl_reg
   import iofd_pkg::*;
#(
   parameter int unsigned REG_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W/8-1:0] be,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata
);
   localparam int unsigned     NLANE   = REG_W / 8;
   localparam logic [15:0]     MASK16  = rw_mask16();
   localparam logic [REG_W-1:0] RW_MASK = REG_W'(MASK16);

   generate
      if ((REG_W % 8) != 0 || REG_W < 8) begin : g_bad_width
         $error("iofd_ctl_reg: REG_W must be a multiple of 8 and at least 8");
      end
   endgenerate

   logic [REG_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         for (int l = 0; l < NLANE; l++) begin
            if (be[l]) begin
               ctl_q[l*8 +: 8] <= wdata[l*8 +: 8] & RW_MASK[l*8 +: 8];
            end
         end
      end
   end

   assign rdata = ctl_q;

   // R3: without a write strobe the control word holds
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rdata));

   // R2: read-only bits stay zero after every write
   a_r2_ro_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rdata & ~RW_MASK) == '0));

endmodule

// File: rtl/iofd_window.sv
module iofd_window #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   output logic              in_win
);
   logic ge_base;
   logic le_limit;

   always_comb begin
      ge_base  = (addr >= base);
      le_limit = (addr <= limit);
      in_win   = ge_base && le_limit;
   end

endmodule

// File: rtl/iofd_vga_match.sv
module iofd_vga_match
   import iofd_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              vga_en,
   input  logic              full_dec,
   output logic              hit
);
   localparam int unsigned UPPER_W = ADDR_W - ALIAS_BITS;

   generate
      if (ADDR_W <= ALIAS_BITS) begin : g_bad_addr
         $error("iofd_vga_match: ADDR_W must exceed the alias span");
      end
   endgenerate

   logic [ALIAS_BITS-1:0] low;
   logic [UPPER_W-1:0]    upper;
   logic [VGA_NRANGE-1:0] range_hit;
   logic                  upper_ok;

   assign low   = addr[ALIAS_BITS-1:0];
   assign upper = addr[ADDR_W-1:ALIAS_BITS];

   generate
      for (genvar r = 0; r < VGA_NRANGE; r++) begin : g_range
         localparam logic [ALIAS_BITS-1:0] LO = ALIAS_BITS'(VGA_LO[r]);
         localparam logic [ALIAS_BITS-1:0] HI = ALIAS_BITS'(VGA_HI[r]);
         assign range_hit[r] = (low >= LO) && (low <= HI);
      end
   endgenerate

   always_comb begin
      upper_ok = !full_dec || (upper == '0);
      hit      = vga_en && upper_ok && (|range_hit);
   end

endmodule

// File: rtl/io_fwd_decoder.sv
module io_fwd_decoder
   import iofd_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned REG_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [REG_W/8-1:0] reg_be,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [ADDR_W-1:0]  io_base,
   input  logic [ADDR_W-1:0]  io_limit,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               fwd_valid,
   output logic               fwd_hit,
   output logic               hot_reset_req
);
   localparam int unsigned HOLE_LSB = ALIAS_BITS - 2;

   generate
      if (REG_W <= SBR_BIT) begin : g_bad_reg
         $error("io_fwd_decoder: REG_W too small for the control bits");
      end
   endgenerate

   logic [REG_W-1:0] ctl;
   logic             win_hit;
   logic             vga_hit;
   logic             isa_hole;
   logic             fwd_d;
   logic             valid_q;
   logic             hit_q;

   iofd_ctl_reg #(.REG_W(REG_W)) i_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr_en),
      .be    (reg_be),
      .wdata (reg_wdata),
      .rdata (ctl)
   );

   iofd_window #(.ADDR_W(ADDR_W)) i_win (
      .addr   (req_addr),
      .base   (io_base),
      .limit  (io_limit),
      .in_win (win_hit)
   );

   iofd_vga_match #(.ADDR_W(ADDR_W)) i_vga (
      .addr     (req_addr),
      .vga_en   (ctl[VGA_BIT]),
      .full_dec (ctl[VGA16_BIT]),
      .hit      (vga_hit)
   );

   always_comb begin
      isa_hole = ctl[ISA_BIT] && (req_addr[ALIAS_BITS-1:HOLE_LSB] != 2'b00);
      fwd_d    = (win_hit && !isa_hole) || vga_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         hit_q   <= 1'b0;
      end else begin
         valid_q <= req_valid;
         hit_q   <= req_valid && fwd_d;
      end
   end

   assign reg_rdata     = ctl;
   assign fwd_valid     = valid_q;
   assign fwd_hit       = hit_q;
   assign hot_reset_req = ctl[SBR_BIT];

   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> fwd_valid);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!fwd_valid && !fwd_hit));

   a_r10_hot_reset: assert property (@(posedge clk) disable iff (!rst_n)
      hot_reset_req == reg_rdata[SBR_BIT]);

   a_r6_outside_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !win_hit && !vga_hit) |=> !fwd_hit);

   a_r5_hole_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && reg_rdata[ISA_BIT] && req_addr[9:8] != 2'b00 && !vga_hit)
      |=> !fwd_hit);

   a_r7_vga_claims: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && vga_hit) |=> fwd_hit);

endmodule

// File: tb/test_io_fwd_decoder.sv
`timescale 1ns/1ps
module test_io_fwd_decoder;
   localparam time TCK = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_be = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] io_base = '0;
   logic [15:0] io_limit = '0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        fwd_valid;
   logic        fwd_hit;
   logic        hot_reset_req;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_ctl = '0;

   always #(TCK/2) clk = ~clk;

   io_fwd_decoder i_io_fwd_decoder (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_be(reg_be), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .io_base(io_base), .io_limit(io_limit),
      .req_valid(req_valid), .req_addr(req_addr),
      .fwd_valid(fwd_valid), .fwd_hit(fwd_hit), .hot_reset_req(hot_reset_req)
   );

   function automatic bit ref_fwd(input logic [15:0] a, input logic [15:0] b,
                                  input logic [15:0] l, input logic [15:0] c);
      int lo;
      bit inwin, hole, vr, vga;
      inwin = (a >= b) && (a <= l);
      hole  = c[2] && (a[9:8] != 2'b00);
      lo    = a % 1024;
      vr    = (lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF);
      vga   = c[3] && vr && (!c[4] || (a / 1024) == 0);
      return (inwin && !hole) || vga;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
   task automatic step(input string tag, input bit wr, input logic [1:0] be,
                       input logic [15:0] wd, input bit v, input logic [15:0] a);
      bit e_val, e_hit;
      reg_wr_en = wr; reg_be = be; reg_wdata = wd; req_valid = v; req_addr = a;
      @(posedge clk);
      e_val = v;
      e_hit = v && ref_fwd(a, io_base, io_limit, m_ctl);
      if (wr && be[0]) m_ctl[7:0] = wd[7:0] & 8'h5C;
      @(negedge clk);
      check(tag, "reg_rdata", reg_rdata, m_ctl);
      check(tag, "hot_reset_req", hot_reset_req, m_ctl[6]);
      check(tag, "fwd_valid", fwd_valid, e_val);
      check(tag, "fwd_hit", fwd_hit, e_hit);
   endtask

   task automatic req(input string tag, input logic [15:0] a);
      step(tag, 1'b0, 2'b00, 16'h0, 1'b1, a);
   endtask

   task automatic wr(input string tag, input logic [15:0] d);
      step(tag, 1'b1, 2'b11, d, 1'b0, 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "reg_rdata", reg_rdata, 0);
      check("R1", "hot_reset_req", hot_reset_req, 0);
      check("R1", "fwd_valid", fwd_valid, 0);
      check("R1", "fwd_hit", fwd_hit, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R10: all ones writes only the RW bits, hot reset follows bit 6
      wr("R2", 16'hFFFF);
      check("R2", "rdata_value", reg_rdata, 16'h005C);
      check("R10", "hot_reset_on", hot_reset_req, 1);
      // R3: low byte lane disabled keeps the value
      step("R3", 1'b1, 2'b10, 16'h0000, 1'b0, 16'h0);
      check("R3", "be_hold", reg_rdata, 16'h005C);
      step("R3", 1'b1, 2'b01, 16'h0000, 1'b0, 16'h0);
      check("R10", "hot_reset_off", hot_reset_req, 0);

      // R4: inclusive window, ISA off
      io_base = 16'h1000; io_limit = 16'h1FFF;
      req("R4", 16'h1000); req("R4", 16'h1FFF); req("R4", 16'h0FFF);
      req("R4", 16'h2000); req("R4", 16'h1100);
      check("R4", "hole_open_with_isa_off", fwd_hit, 1);
      io_base = 16'h3000; io_limit = 16'h2000;
      req("R4", 16'h2800);
      check("R4", "empty_window", fwd_hit, 0);

      // R5 R6: ISA hole
      io_base = 16'h1000; io_limit = 16'h1FFF;
      wr("R5", 16'h0004);
      req("R5", 16'h1000); req("R5", 16'h1100); req("R5", 16'h13FF);
      req("R5", 16'h1400); req("R6", 16'h0100); req("R6", 16'h0000);

      // R7: VGA 10-bit decode outside the window and inside the hole
      wr("R7", 16'h0008);
      req("R7", 16'h03B0); req("R7", 16'h03BB); req("R7", 16'h03BC);
      req("R7", 16'h03C0); req("R7", 16'h03DF); req("R7", 16'h03E0);
      req("R8", 16'h07C0);
      check("R8", "alias_10bit", fwd_hit, 1);
      io_base = 16'h0000; io_limit = 16'h0FFF;
      wr("R7", 16'h000C);
      req("R7", 16'h03C5); req("R7", 16'h0390);
      // R8: full decode
      wr("R8", 16'h0018);
      req("R8", 16'h07C0); req("R8", 16'h03C0); req("R8", 16'hF3D0);
      // R9: 16-bit select without VGA enable
      io_base = 16'h8000; io_limit = 16'h8FFF;
      wr("R9", 16'h0010);
      req("R9", 16'h03C0); req("R9", 16'h07C0);

      // R11: same-cycle write uses old control, idle gives no valid
      step("R11", 1'b1, 2'b01, 16'h0008, 1'b1, 16'h03C0);
      check("R11", "old_ctl_used", fwd_hit, 0);
      step("R11", 1'b0, 2'b00, 16'h0, 1'b0, 16'h03C0);
      req("R11", 16'h03C0);

      // Random mix across all requirements
      for (int i = 0; i < 600; i++) begin
         if ((i % 50) == 0) begin
            io_base  = 16'($urandom_range(0, 16'h2000));
            io_limit = 16'($urandom_range(0, 16'h3000));
         end
         step("R11", ($urandom % 8) == 0, 2'($urandom), 16'($urandom),
              ($urandom % 4) != 0,
              (($urandom % 2) == 0) ? 16'($urandom) : 16'($urandom_range(0, 16'h0FFF)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(TCK * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule